// File: doc/BRIEF.md
# Sequential Fixed-Point Divider

This block divides one signed fixed-point number by another over a fixed number of clock cycles. Both operands and the quotient use the same N-bit sign-magnitude layout: bit N-1 is the sign, bits N-2 down to Q hold the integer part and bits Q-1 down to 0 hold the fraction. The magnitude of the dividend is widened with Q zero fraction bits. A restoring compare-and-subtract loop then produces one quotient bit per cycle, so the quotient keeps Q fraction bits.

A caller waits for the done flag, places the operands on the inputs and raises start for one cycle. Done drops, and after a latency that does not depend on the operand values the quotient and an overflow flag appear and done rises again. Start is only heard while done is high. The overflow flag covers two cases: a quotient too large for the format, and a zero divisor.

Top module: `fxp_divider`

## Requirements
- R1: The quotient magnitude (bits N-2:0) equals floor(|dividend| * 2^Q / |divisor|), truncated to its low N-1 bits. Magnitudes are bits N-2:0 of each operand.
- R2: After reset, doneOut is 1, quotientOut is 0 and overflowOut is 0.
- R3: An operation is accepted only at a rising edge where doneOut and startIn are both 1. A start while doneOut is 0 has no effect on the result or on the timing.
- R4: After the accepting edge, doneOut stays 0 for exactly N+Q cycles. It rises at the (N+Q+1)th edge, counting the accepting edge as the first, and the result is valid from then on.
- R5: The operands are captured at the accepting edge. Later changes on dividendIn or divisorIn do not alter that operation's result.
- R6: The quotient sign (bit N-1) is the XOR of the two operand signs, forced to 0 when the quotient magnitude is zero.
- R7: overflowOut is 1 when the exact quotient magnitude floor(|dividend| * 2^Q / |divisor|) is 2^(N-1) or more, and 0 otherwise for a nonzero divisor.
- R8: A divisor magnitude of zero (either sign) sets overflowOut to 1 and gives a quotient magnitude of all ones, with the sign still following R6.
- R9: quotientOut and overflowOut hold their values from one completion until the next completion.
- R10: If startIn is still 1 when doneOut rises, the next edge accepts a new operation, so doneOut is 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| dividendIn | input | N | Dividend, sign-magnitude fixed point |
| divisorIn | input | N | Divisor, sign-magnitude fixed point |
| startIn | input | 1 | Start request, heard only while doneOut is 1 |
| quotientOut | output | N | Quotient, sign-magnitude fixed point |
| doneOut | output | 1 | 1 when idle and the last result is valid |
| overflowOut | output | 1 | Quotient not representable, or divisor zero |

## Verification
Completion of one division and acceptance of the next can fall on neighbouring edges: done rises and, with start still held, the very next edge loads new operands. The bench provokes this by keeping start high through a whole operation and swapping the operands as soon as done is seen. It then judges three things: the first result, that done is high for exactly one sampled cycle, and the second result with its shortened observed low period. Start pulses and operand changes during a busy period are injected as well, and checked for having no effect on the latency or the quotient.

// File: rtl/fxp_div_pkg.sv
package fxp_div_pkg;

  // Strobes driven by the sequencer into the arithmetic datapath
  typedef struct packed {
    logic load;    // capture operands, clear accumulators
    logic step;    // one compare-and-subtract iteration
    logic finish;  // publish quotient and overflow
  } divStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divState_t;

endpackage

// File: rtl/fxp_div_stage.sv
// One restoring division step: shift in a dividend bit, subtract when possible.
module fxp_div_stage #(
  parameter int MW = 15
) (
  input  logic [MW-1:0] remIn,
  input  logic          bitIn,
  input  logic [MW-1:0] dmag,
  output logic [MW-1:0] remOut,
  output logic          qBit
);
  logic [MW:0] remShift;
  logic [MW:0] diff;

  always_comb begin
    remShift = {remIn, bitIn};
    diff     = remShift - {1'b0, dmag};
    qBit     = (remShift >= {1'b0, dmag});
    remOut   = qBit ? diff[MW-1:0] : remShift[MW-1:0];
  end
endmodule

// File: rtl/fxp_div_ctrl.sv
module fxp_div_ctrl
  import fxp_div_pkg::*;
#(
  parameter int ITER = 23
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output logic        done,
  output divStrobes_t strobes
);
  localparam int CW = $clog2(ITER + 1);

  divState_t state;
  logic [CW-1:0] iterCnt;

  assign done = (state == ST_IDLE);

  always_comb begin
    strobes.load   = (state == ST_IDLE) && start;
    strobes.step   = (state == ST_RUN);
    strobes.finish = (state == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == CW'(ITER - 1)) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Checker counter: cycles spent busy since the last accepted start
  logic [CW:0] busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN)             busyCnt <= '0;
    else if (strobes.load) busyCnt <= '0;
    else if (!done)        busyCnt <= busyCnt + 1'b1;
  end

  // R4: done returns after exactly ITER+1 = N+Q busy cycles
  assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> busyCnt == (CW+1)'(ITER + 1));

  // R3: done can only fall after a start seen while done was high
  assert_start_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(done) |-> ($past(start) && $past(done)));

  // R3: a busy sequencer never re-enters the run state from the finish state
  assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIN) |=> done);
endmodule

// File: rtl/fxp_div_datapath.sv
module fxp_div_datapath
  import fxp_div_pkg::*;
#(
  parameter int N = 16,
  parameter int Q = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  divStrobes_t strobes,
  input  logic [N-1:0] dividendIn,
  input  logic [N-1:0] divisorIn,
  output logic [N-1:0] quotOut,
  output logic         ovfOut
);
  localparam int MW = N - 1;      // magnitude width
  localparam int QW = N - 1 + Q;  // full quotient magnitude width

  logic [QW-1:0] dvdSh;
  logic [QW-1:0] qAcc;
  logic [MW-1:0] dmag;
  logic [MW-1:0] rem;
  logic          qSign;
  logic [MW-1:0] remNext;
  logic          qBit;
  logic          highBits;

  fxp_div_stage #(.MW(MW)) u_stage (
    .remIn (rem),
    .bitIn (dvdSh[QW-1]),
    .dmag  (dmag),
    .remOut(remNext),
    .qBit  (qBit)
  );

  generate
    if (Q > 0) begin : g_frac
      assign highBits = |qAcc[QW-1:MW];
    end else begin : g_nofrac
      assign highBits = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dvdSh   <= '0;
      qAcc    <= '0;
      dmag    <= '0;
      rem     <= '0;
      qSign   <= 1'b0;
      quotOut <= '0;
      ovfOut  <= 1'b0;
    end else begin
      if (strobes.load) begin
        dvdSh <= QW'(dividendIn[N-2:0]) << Q;
        dmag  <= divisorIn[N-2:0];
        qSign <= dividendIn[N-1] ^ divisorIn[N-1];
        rem   <= '0;
        qAcc  <= '0;
      end else if (strobes.step) begin
        rem   <= remNext;
        qAcc  <= {qAcc[QW-2:0], qBit};
        dvdSh <= dvdSh << 1;
      end
      if (strobes.finish) begin
        quotOut <= {qSign && (|qAcc[MW-1:0]), qAcc[MW-1:0]};
        ovfOut  <= highBits || (dmag == '0);
      end
    end
  end

  // R1: partial remainder stays below the divisor after every step
  assert_rem_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && dmag != '0) |=> rem < dmag);

  // R9: published result only moves on a finish strobe
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> ($stable(quotOut) && $stable(ovfOut)));

  // R6: a negative sign never accompanies a zero magnitude
  assert_no_neg_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    quotOut[N-1] |-> (quotOut[N-2:0] != '0));

  // R8: a zero divisor always yields the overflow flag
  assert_zero_div_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.finish && dmag == '0) |=> ovfOut);
endmodule

// File: rtl/fxp_divider.sv
module fxp_divider
  import fxp_div_pkg::*;
#(
  parameter int N = 16,
  parameter int Q = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [N-1:0] dividendIn,
  input  logic [N-1:0] divisorIn,
  input  logic         startIn,
  output logic [N-1:0] quotientOut,
  output logic         doneOut,
  output logic         overflowOut
);
  localparam int ITER = N + Q - 1;

  divStrobes_t strobes;

  fxp_div_ctrl #(.ITER(ITER)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (startIn),
    .done   (doneOut),
    .strobes(strobes)
  );

  fxp_div_datapath #(.N(N), .Q(Q)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dividendIn(dividendIn),
    .divisorIn (divisorIn),
    .quotOut   (quotientOut),
    .ovfOut    (overflowOut)
  );
endmodule

// File: tb/fxp_divider_bench.sv
module fxp_divider_bench;
  localparam int N  = 16;
  localparam int Q  = 8;
  localparam int MW = N - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] dividendIn = '0;
  logic [N-1:0] divisorIn = '0;
  logic startIn = 1'b0;
  logic [N-1:0] quotientOut;
  logic doneOut;
  logic overflowOut;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fxp_divider #(.N(N), .Q(Q)) u_fxp_divider (
    .clk(clk), .rstN(rstN), .dividendIn(dividendIn), .divisorIn(divisorIn),
    .startIn(startIn), .quotientOut(quotientOut), .doneOut(doneOut),
    .overflowOut(overflowOut)
  );

  function automatic longint unsigned fullMag(logic [N-1:0] a, logic [N-1:0] b);
    longint unsigned num = longint'(a[N-2:0]) << Q;
    longint unsigned den = longint'(b[N-2:0]);
    if (den == 0) return (64'd1 << (MW + Q)) - 1;
    return num / den;
  endfunction

  function automatic logic [N-1:0] modelQuot(logic [N-1:0] a, logic [N-1:0] b);
    logic [MW-1:0] mag = MW'(fullMag(a, b));
    return {(a[N-1] ^ b[N-1]) && (mag != '0), mag};
  endfunction

  function automatic logic modelOvf(logic [N-1:0] a, logic [N-1:0] b);
    return (b[N-2:0] == '0) || (fullMag(a, b) >= (64'd1 << MW));
  endfunction

  task automatic check(string req, longint unsigned act, longint unsigned exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Waits for done after an accepting edge; returns low-cycle count and stability
  task automatic waitDone(input bit disturb, output int lowCnt, output bit stableOk);
    logic [N-1:0] holdQ = quotientOut;
    logic holdO = overflowOut;
    lowCnt = 0;
    stableOk = 1'b1;
    while (lowCnt < 500) begin
      @(negedge clk);
      if (doneOut) break;
      lowCnt++;
      if (quotientOut !== holdQ || overflowOut !== holdO) stableOk = 1'b0;
      if (disturb) begin
        dividendIn = N'($urandom);
        divisorIn  = N'($urandom);
        startIn    = (lowCnt < 4);
      end else begin
        startIn = 1'b0;
      end
    end
    startIn = 1'b0;
  endtask

  task automatic runOp(logic [N-1:0] a, logic [N-1:0] b, bit disturb, string tag);
    int lowCnt;
    bit stableOk;
    @(negedge clk);
    dividendIn = a;
    divisorIn  = b;
    startIn    = 1'b1;
    @(posedge clk);
    #1 startIn = 1'b0;
    waitDone(disturb, lowCnt, stableOk);
    check("R4", lowCnt, N + Q, {tag, " busy cycles"});
    check("R1/R6", quotientOut, modelQuot(a, b), {tag, " quotient"});
    check("R7", overflowOut, modelOvf(a, b), {tag, " overflow"});
    check("R9", stableOk, 1, {tag, " outputs held while busy"});
    if (disturb) check("R3/R5", quotientOut, modelQuot(a, b), {tag, " result after busy disturbance"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lowCnt;
    bit stableOk;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2", doneOut, 1, "done after reset");
    check("R2", quotientOut, 0, "quotient after reset");
    check("R2", overflowOut, 0, "overflow after reset");

    // R3: no start means no operation
    repeat (5) @(negedge clk);
    check("R3", doneOut, 1, "done stays high without start");

    // Directed cases (Q=8: 0x0100 is 1.0)
    runOp(16'h0180, 16'h0080, 0, "1.5/0.5");
    runOp(16'h8180, 16'h0080, 0, "-1.5/0.5 R6");
    runOp(16'h8180, 16'h8080, 0, "-1.5/-0.5 R6");
    runOp(16'h0100, 16'h0300, 0, "1/3 R1");
    runOp(16'h0000, 16'h0123, 0, "zero dividend");
    runOp(16'h8000, 16'h0100, 0, "negative zero R6");
    runOp(16'h0280, 16'h0000, 0, "div by zero R8");
    runOp(16'h8280, 16'h8000, 0, "div by neg zero R8");
    check("R8", quotientOut, 16'h7FFF, "neg zero divisor magnitude");
    runOp(16'h4000, 16'h0080, 0, "exact 2^15 R7");
    runOp(16'hC000, 16'h0080, 0, "negative overflow zero mag R7");
    runOp(16'h4000, 16'h0081, 0, "just below overflow R7");
    runOp(16'h7FFF, 16'h0001, 0, "max/min R7");
    runOp(16'h0001, 16'h7FFF, 0, "min/max R1");
    runOp(16'h1234, 16'h0567, 1, "disturbed R5");

    // R10: start held high across completion
    @(negedge clk);
    dividendIn = 16'h0300;
    divisorIn  = 16'h0200;
    startIn    = 1'b1;
    @(posedge clk);
    lowCnt = 0;
    while (lowCnt < 500) begin
      @(negedge clk);
      if (doneOut) break;
      lowCnt++;
    end
    check("R10", quotientOut, modelQuot(16'h0300, 16'h0200), "first of back-to-back");
    dividendIn = 16'h8500;
    divisorIn  = 16'h0140;
    @(negedge clk);
    check("R10", doneOut, 0, "done high for one cycle only");
    startIn = 1'b0;
    waitDone(0, lowCnt, stableOk);
    check("R10", lowCnt, N + Q - 1, "second op remaining busy cycles");
    check("R10", quotientOut, modelQuot(16'h8500, 16'h0140), "second of back-to-back");
    check("R10", overflowOut, modelOvf(16'h8500, 16'h0140), "second overflow");

    // Constrained random operands
    for (int i = 0; i < 40; i++) begin
      logic [N-1:0] a = N'($urandom);
      logic [N-1:0] b = N'($urandom);
      if (i % 4 == 1) b[N-2:0] = MW'(b[N-2:0] >> ($urandom % 12));
      if (i % 4 == 2) a[N-2:0] = MW'(a[N-2:0] >> ($urandom % 10));
      runOp(a, b, (i % 3 == 0), "random R1");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule